// File: doc/BRIEF.md
# IOMMU Fault and Control Register Block

This block is the register front end of a translation unit that guards one bus master. Software uses a small register bus to do four things: switch translation off, on, or on with the master held; choose the first-level table size; program the page-table base; and ask for a full TLB invalidation. The page-table walker, the TLB and the datapath sit outside the block. The walker reports faults through an event port that carries a fault type and the faulting address. The TLB takes a one-cycle invalidate pulse.

There are eight fault types. Each type has a bit in a status register, and those bits drive one level interrupt. Every fault type maps to one of four shared address registers, and the faulting address is kept there. A fault automatically places the unit in the held state. The master stays stalled until software writes the run code again. Software then clears the status bits it has handled by writing ones to them.

Top module: `mmu_fault_ctl`

## Requirements
- R1: After reset the mode reads 0x0, status, configuration and base read 0, and `xlate_en`, `stall_master`, `irq` and `flush_pulse` are all low.
- R2: The mode register is at offset 0x00. Writing 0x5 selects run (`xlate_en`=1, `stall_master`=0). Writing 0x7 selects held (`xlate_en`=1, `stall_master`=1). Writing 0x0 selects off. Any other written value leaves the mode unchanged.
- R3: When a fault event arrives in run or held mode, status bit `flt_type` is set at the next edge (status is at offset 0x10, bit n = type n). At the same edge `irq` rises and the mode becomes held.
- R4: Fault events that arrive while the mode is off change neither the status nor any address register.
- R5: Fault types are 0 page, 1 read multi-hit, 2 write multi-hit, 3 bus error, 4 read security, 5 read access, 6 write security, 7 write access. The address is captured as follows: type 0 goes to the page register (0x18), types 1, 4 and 5 to the read register (0x1C), types 2, 6 and 7 to the write register (0x20), and type 3 to the default-slave register (0x24).
- R6: If a fault arrives while its own status bit is already set, the captured address is kept. A different type that shares the same register and whose bit is clear overwrites it.
- R7: Writing to offset 0x14 clears every status bit whose write-data bit is 1. `irq` stays high until every status bit is clear.
- R8: Writing 0x5 while held releases `stall_master` and leaves the status bits unchanged.
- R9: Writing a value with bit 0 set to offset 0x0C produces a `flush_pulse` that is high for exactly one cycle after the write edge. Writing 0 there gives no pulse, and the offset always reads 0.
- R10: The configuration register is at 0x04. Bit 5 set selects a 4 KB table and reads back as 0x20; bit 5 clear selects a 16 KB table and reads back as 0x0. The base at 0x08 (also on `pt_base`) has its low 12 bits forced to zero in 4 KB mode and its low 14 bits forced to zero in 16 KB mode.
- R11: If a fault and a write of 0x5 to the mode register land on the same edge, the fault wins and the mode becomes held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high (with bus_sel) |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| flt_valid | input | 1 | Fault event from the walker |
| flt_type | input | 3 | Fault type 0..7 |
| flt_addr | input | VA_W | Faulting address |
| xlate_en | output | 1 | Translation enabled (run or held) |
| stall_master | output | 1 | Master is held |
| irq | output | 1 | Level interrupt, OR of status bits |
| flush_pulse | output | 1 | One-cycle TLB invalidate |
| pt_base | output | 32 | Aligned page-table base |
| tbl_4k | output | 1 | 4 KB first-level table selected |

## Verification
The bench uses the default parameters: an 8-bit register offset and a 32-bit fault address. With these, all ten register offsets can be reached, and the full address appears in each capture register. Each of the eight fault types is driven in turn, so every route to the four shared capture registers is exercised. The width also lets the base mask be checked against 16 KB and 4 KB alignment on a full 32-bit value.

// File: rtl/mmu_fault_pkg.sv
package mmu_fault_pkg;
  localparam int BUS_W = 32;
  localparam int NTYPE = 8;
  localparam int NSLOT = 4;

  typedef enum logic [2:0] {
    MODE_OFF  = 3'h0,
    MODE_RUN  = 3'h5,
    MODE_HOLD = 3'h7
  } mode_e;

  localparam logic [7:0] OFS_MODE   = 8'h00;
  localparam logic [7:0] OFS_CFG    = 8'h04;
  localparam logic [7:0] OFS_BASE   = 8'h08;
  localparam logic [7:0] OFS_FLUSH  = 8'h0C;
  localparam logic [7:0] OFS_STAT   = 8'h10;
  localparam logic [7:0] OFS_CLR    = 8'h14;
  localparam logic [7:0] OFS_SLOT0  = 8'h18;

  // Which shared capture register a fault type lands in.
  function automatic logic [1:0] slot_of(input logic [2:0] t);
    case (t)
      3'd0:             slot_of = 2'd0;
      3'd3:             slot_of = 2'd3;
      3'd1, 3'd4, 3'd5: slot_of = 2'd1;
      default:          slot_of = 2'd2;
    endcase
  endfunction

  // Alignment mask for the table base.
  function automatic logic [BUS_W-1:0] base_mask(input logic small_tbl);
    base_mask = small_tbl ? 32'hFFFF_F000 : 32'hFFFF_C000;
  endfunction
endpackage

// File: rtl/mmu_ctl_regs.sv
module mmu_ctl_regs
  import mmu_fault_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              fault_take,
  output mode_e             mode_q,
  output logic              small_tbl,
  output logic [BUS_W-1:0]  base_aligned,
  output logic              flush_pulse
);
  logic [BUS_W-1:0] base_q;
  logic             wr_mode, wr_cfg, wr_base, wr_flush, code_ok;

  assign wr_mode  = wr_en && (wr_addr == ADDR_W'(OFS_MODE));
  assign wr_cfg   = wr_en && (wr_addr == ADDR_W'(OFS_CFG));
  assign wr_base  = wr_en && (wr_addr == ADDR_W'(OFS_BASE));
  assign wr_flush = wr_en && (wr_addr == ADDR_W'(OFS_FLUSH));
  assign code_ok  = (wr_data == BUS_W'(MODE_OFF)) || (wr_data == BUS_W'(MODE_RUN)) ||
                    (wr_data == BUS_W'(MODE_HOLD));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q      <= MODE_OFF;
      small_tbl   <= 1'b0;
      base_q      <= '0;
      flush_pulse <= 1'b0;
    end else begin
      if (fault_take)            mode_q <= MODE_HOLD;
      else if (wr_mode && code_ok) mode_q <= mode_e'(wr_data[2:0]);
      if (wr_cfg)  small_tbl <= wr_data[5];
      if (wr_base) base_q    <= wr_data;
      flush_pulse <= wr_flush && wr_data[0];
    end
  end

  assign base_aligned = base_q & base_mask(small_tbl);

  assert_fault_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fault_take |=> (mode_q == MODE_HOLD));
  assert_bad_code_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && !code_ok && !fault_take) |=> $stable(mode_q));
  assert_flush_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pulse |=> !flush_pulse);
endmodule

// File: rtl/mmu_fault_capture.sv
module mmu_fault_capture
  import mmu_fault_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        accept_ok,
  input  logic                        flt_valid,
  input  logic [2:0]                  flt_type,
  input  logic [VA_W-1:0]             flt_addr,
  input  logic                        clr_en,
  input  logic [NTYPE-1:0]            clr_mask,
  output logic                        fault_take,
  output logic [NTYPE-1:0]            status_q,
  output logic [NSLOT-1:0][VA_W-1:0]  slot_addr
);
  logic [NTYPE-1:0] set_vec, clr_vec;
  logic             fresh;

  assign fault_take = flt_valid && accept_ok;
  assign set_vec    = fault_take ? (NTYPE'(1) << flt_type) : '0;
  assign clr_vec    = clr_en ? clr_mask : '0;
  assign fresh      = fault_take && !status_q[flt_type];

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_vec) | set_vec;
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [VA_W-1:0] cap_q;
    always_ff @(posedge clk) begin
      if (!rst_n) cap_q <= '0;
      else if (fresh && (slot_of(flt_type) == 2'(s))) cap_q <= flt_addr;
    end
    assign slot_addr[s] = cap_q;
  end

  assert_fault_sets_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fault_take |=> status_q[$past(flt_type)]);
  assert_off_ignores_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_ok |=> ((status_q & ~$past(status_q)) == '0) && $stable(slot_addr));
  assert_sticky_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_take && status_q[flt_type]) |=> $stable(slot_addr));
endmodule

// File: rtl/mmu_fault_ctl.sv
module mmu_fault_ctl
  import mmu_fault_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int VA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              flt_valid,
  input  logic [2:0]        flt_type,
  input  logic [VA_W-1:0]   flt_addr,
  output logic              xlate_en,
  output logic              stall_master,
  output logic              irq,
  output logic              flush_pulse,
  output logic [31:0]       pt_base,
  output logic              tbl_4k
);
  mode_e                     mode_q;
  logic                      wr_en, clr_en, fault_take;
  logic [NTYPE-1:0]          status_q;
  logic [NSLOT-1:0][VA_W-1:0] slot_addr;

  assign wr_en  = bus_sel && bus_we;
  assign clr_en = wr_en && (bus_addr == ADDR_W'(OFS_CLR));

  mmu_ctl_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(bus_addr), .wr_data(bus_wdata),
    .fault_take(fault_take), .mode_q(mode_q), .small_tbl(tbl_4k),
    .base_aligned(pt_base), .flush_pulse(flush_pulse)
  );

  mmu_fault_capture #(.VA_W(VA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .accept_ok(mode_q != MODE_OFF),
    .flt_valid(flt_valid), .flt_type(flt_type), .flt_addr(flt_addr),
    .clr_en(clr_en), .clr_mask(bus_wdata[NTYPE-1:0]),
    .fault_take(fault_take), .status_q(status_q), .slot_addr(slot_addr)
  );

  assign xlate_en     = (mode_q != MODE_OFF);
  assign stall_master = (mode_q == MODE_HOLD);
  assign irq          = |status_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_MODE))      bus_rdata = 32'(mode_q);
    else if (bus_addr == ADDR_W'(OFS_CFG))  bus_rdata = tbl_4k ? 32'h20 : 32'h0;
    else if (bus_addr == ADDR_W'(OFS_BASE)) bus_rdata = pt_base;
    else if (bus_addr == ADDR_W'(OFS_STAT)) bus_rdata = 32'(status_q);
    for (int s = 0; s < NSLOT; s++)
      if (bus_addr == ADDR_W'(OFS_SLOT0 + 8'(4 * s))) bus_rdata = 32'(slot_addr[s]);
  end

  assert_irq_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_en) |=> irq);
  assert_base_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_4k ? (pt_base[11:0] == 12'h0) : (pt_base[13:0] == 14'h0));
endmodule

// File: tb/tb_mmu_fault_ctl.sv
`timescale 1ns/1ps
module tb_mmu_fault_ctl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_sel = 0, bus_we = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        flt_valid = 0;
  logic [2:0]  flt_type = '0;
  logic [31:0] flt_addr = '0;
  logic        xlate_en, stall_master, irq, flush_pulse, tbl_4k;
  logic [31:0] pt_base;
  int checks = 0, errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  mmu_fault_ctl dut (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic fault(input logic [2:0] t, input logic [31:0] a);
    @(negedge clk);
    flt_valid = 1; flt_type = t; flt_addr = a;
    @(negedge clk);
    flt_valid = 0;
  endtask

  function automatic logic [7:0] exp_reg(input int t);
    if (t == 0) return 8'h18;
    if (t == 3) return 8'h24;
    if (t == 1 || t == 4 || t == 5) return 8'h1C;
    return 8'h20;
  endfunction

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 xlate", 32'(xlate_en), 0);
    chk("R1 stall", 32'(stall_master), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 flush", 32'(flush_pulse), 0);
    rd(8'h00, v); chk("R1 mode", v, 0);
    rd(8'h10, v); chk("R1 status", v, 0);
    rd(8'h04, v); chk("R1 cfg", v, 0);
    rd(8'h08, v); chk("R1 base", v, 0);
  endtask

  task automatic t_modes;
    logic [31:0] v;
    wr(8'h00, 32'h5);
    chk("R2 run xlate", 32'(xlate_en), 1); chk("R2 run stall", 32'(stall_master), 0);
    rd(8'h00, v); chk("R2 run read", v, 5);
    wr(8'h00, 32'h7);
    chk("R2 hold stall", 32'(stall_master), 1);
    wr(8'h00, 32'h3);
    rd(8'h00, v); chk("R2 bad code ignored", v, 7);
    chk("R2 bad code stall", 32'(stall_master), 1);
    wr(8'h00, 32'h0);
    chk("R2 off xlate", 32'(xlate_en), 0);
  endtask

  task automatic t_off_ignore;
    logic [31:0] v;
    fault(3'd2, 32'hAAAA_0000);
    rd(8'h10, v); chk("R4 status off", v, 0);
    rd(8'h20, v); chk("R4 addr off", v, 0);
    chk("R4 irq off", 32'(irq), 0);
  endtask

  task automatic t_route;
    logic [31:0] v;
    wr(8'h00, 32'h5);
    for (int t = 0; t < 8; t++) begin
      fault(3'(t), 32'h1000_0000 + 32'(t) * 32'h111);
      chk("R3 stall", 32'(stall_master), 1);
      chk("R3 irq", 32'(irq), 1);
      rd(8'h10, v); chk("R3 status bit", v, 32'(1) << t);
      rd(exp_reg(t), v); chk("R5 routed addr", v, 32'h1000_0000 + 32'(t) * 32'h111);
      wr(8'h14, 32'(1) << t);
      chk("R7 cleared irq", 32'(irq), 0);
      wr(8'h00, 32'h5);
      chk("R8 released", 32'(stall_master), 0);
    end
  endtask

  task automatic t_sticky;
    logic [31:0] v;
    fault(3'd1, 32'h0000_A000);
    fault(3'd1, 32'h0000_B000);
    rd(8'h1C, v); chk("R6 kept addr", v, 32'h0000_A000);
    fault(3'd4, 32'h0000_C000);
    rd(8'h1C, v); chk("R6 shared overwrite", v, 32'h0000_C000);
    wr(8'h00, 32'h5);
    chk("R8 stall off", 32'(stall_master), 0);
    rd(8'h10, v); chk("R8 status kept", v, 32'h12);
    wr(8'h14, 32'h02);
    chk("R7 irq stays", 32'(irq), 1);
    rd(8'h10, v); chk("R7 partial clear", v, 32'h10);
    wr(8'h14, 32'h10);
    chk("R7 irq drops", 32'(irq), 0);
  endtask

  task automatic t_race;
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = 8'h00; bus_wdata = 32'h5;
    flt_valid = 1; flt_type = 3'd0; flt_addr = 32'h5555_0000;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; flt_valid = 0;
    chk("R11 fault wins", 32'(stall_master), 1);
    wr(8'h14, 32'h01);
    wr(8'h00, 32'h5);
  endtask

  task automatic t_flush;
    logic [31:0] v;
    wr(8'h0C, 32'h1);
    chk("R9 pulse high", 32'(flush_pulse), 1);
    @(negedge clk);
    chk("R9 pulse one cycle", 32'(flush_pulse), 0);
    rd(8'h0C, v); chk("R9 reads zero", v, 0);
    wr(8'h0C, 32'h0);
    chk("R9 no pulse on zero", 32'(flush_pulse), 0);
  endtask

  task automatic t_cfg;
    logic [31:0] v;
    wr(8'h08, 32'hDEAD_BEEF);
    rd(8'h08, v); chk("R10 16K base", v, 32'hDEAD_8000);
    wr(8'h04, 32'h20);
    rd(8'h04, v); chk("R10 cfg read", v, 32'h20);
    chk("R10 4K flag", 32'(tbl_4k), 1);
    chk("R10 4K base port", pt_base, 32'hDEAD_B000);
    wr(8'h04, 32'h0);
    rd(8'h08, v); chk("R10 back to 16K", v, 32'hDEAD_8000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_modes;
    t_off_ignore;
    t_route;
    t_sticky;
    t_race;
    t_flush;
    t_cfg;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule